// File: doc/BRIEF.md
# Floating-Point Adder Front End

This block takes two binary floating-point operands (IEEE 754 single precision by default) and carries out everything in an addition except the final rounding. A result that needs no rounding comes out as a finished word with a flag set. Such results are NaN propagation, infinity and zero cases, exact cancellation, and an operand added to zero. Every other result is passed on as a sign, a signed biased exponent and a normalized significand. The significand keeps three extra low bits (guard, round, sticky) so that a rounder stage downstream can finish the job.

Each operand is sorted into a class: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. An optional flush control turns subnormal inputs into zeros first. Subnormal inputs that are not flushed are normalized, which gives both significands a leading one. The operand with the smaller exponent is then shifted right to line up with the other, and any bits lost in the shift are gathered into the sticky bit. The aligned significands are added or subtracted, and the result is renormalized. The exponent and fraction widths are parameters, and one register stage sits on the output.

Top module: `fpadd_core`

## Requirements
- R1: A signaling NaN (exponent all ones, nonzero fraction, top fraction bit 0) in operand A gives A with its top fraction bit set, even when B is also signaling. If only B is signaling, the result is B with that bit set. Either case sets `invalid_o` and `special_o`.
- R2: If neither operand is signaling, a quiet NaN in A is returned unchanged. Otherwise a quiet NaN in B is returned unchanged. `invalid_o` stays low.
- R3: Two infinities of equal sign return A. Two infinities of opposite sign return the `DEF_NAN` parameter and set `invalid_o`. An infinity with any finite operand returns the infinity.
- R4: Two zeros of equal sign return that zero. Two zeros of opposite sign return +0, or -0 when `rnd_mode_i` is 2'b11 (toward minus infinity). A zero with a nonzero finite operand returns the other operand word.
- R5: While `ftz_i` is high, a subnormal input behaves as a zero of the same sign.
- R6: While `ftz_i` is low, a subnormal input enters the arithmetic at its exact value, normalized so that it carries a leading one.
- R7: The significand with the smaller exponent is shifted right by the exponent difference. Any 1 bit shifted out is ORed into bit 0. The result takes the larger exponent.
- R8: For equal signs, a sum that reaches bit SIG_W is shifted right by one with sticky preserved, and the exponent goes up by one.
- R9: For unequal signs, the smaller aligned significand is subtracted from the larger, and the result takes the larger one's sign. An exactly zero difference gives a finished zero whose sign follows R4's rounding rule.
- R10: A non-special result has `sig_o[SIG_W-1]` set. The exponent drops by one for each left shift that was needed.
- R11: `valid_o` equals `valid_i` one clock earlier. `special_o` and `invalid_o` are low whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| op_a_i | input | 1+EXP_W+FRAC_W | Operand A |
| op_b_i | input | 1+EXP_W+FRAC_W | Operand B |
| rnd_mode_i | input | 2 | Rounding mode; 2'b11 is toward minus infinity |
| ftz_i | input | 1 | Treat subnormal inputs as zero |
| valid_o | output | 1 | Result present |
| special_o | output | 1 | `special_word_o` holds the final result |
| special_word_o | output | 1+EXP_W+FRAC_W | Finished result word |
| sign_o | output | 1 | Intermediate sign |
| exp_o | output | EXP_W+2 | Intermediate biased exponent, two's complement |
| sig_o | output | FRAC_W+4 | Normalized significand with guard, round and sticky bits |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
All results arrive together one clock after the stimulus is accepted: the valid strobe, the special word, the flags and the intermediate fields. The bench applies one operand pair at a falling edge and samples 2 ns after the rising edge that follows. Every comparison therefore reads the register that captured exactly that pair. Idle cycles between valid pulses check that the strobe and flags drop on the very next sample. An 8-bit format instance with 4 exponent bits and 3 fraction bits is swept over every operand pair. A second pass sweeps every pair that contains a subnormal with flushing on. The single-precision instance receives directed corner cases.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO, CLS_NORM, CLS_DNRM, CLS_INF, CLS_QNAN, CLS_SNAN
  } op_cls_e;

  localparam logic [1:0] RM_DOWN = 2'b11;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int XE_W  = EXP_W + 2,
  localparam int SIG_W = FRAC_W + 4
) (
  input  logic [OP_W-1:0]         op_i,
  input  logic                    ftz_i,
  output op_cls_e                 cls_o,
  output logic                    sign_o,
  output logic signed [XE_W-1:0]  exp_o,
  output logic [SIG_W-1:0]        sig_o
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [FRAC_W:0]   dn_m;
  logic [XE_W-1:0]   dn_sh;

  assign sign_o = op_i[OP_W-1];
  assign e      = op_i[OP_W-2 -: EXP_W];
  assign f      = op_i[FRAC_W-1:0];

  always_comb begin
    if (e == '0)     cls_o = (f == '0 || ftz_i) ? CLS_ZERO : CLS_DNRM;
    else if (&e)     cls_o = (f == '0) ? CLS_INF : (f[FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
    else             cls_o = CLS_NORM;
  end

  // subnormal: shift leading one up to the hidden position
  always_comb begin
    dn_sh = '0;
    for (int i = 0; i < FRAC_W; i++)
      if (f[i]) dn_sh = XE_W'(FRAC_W - i);
    dn_m = {1'b0, f} << dn_sh;
  end

  always_comb begin
    exp_o = '0;
    sig_o = '0;
    if (cls_o == CLS_NORM) begin
      exp_o = $signed({2'b00, e});
      sig_o = {1'b1, f, 3'b000};
    end else if (cls_o == CLS_DNRM) begin
      exp_o = $signed(XE_W'(XE_W'(1) - dn_sh));
      sig_o = {dn_m, 3'b000};
    end
  end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  parameter logic [OP_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
) (
  input  op_cls_e          cls_x_i,
  input  op_cls_e          cls_y_i,
  input  logic             sx_i,
  input  logic             sy_i,
  input  logic [OP_W-1:0]  op_x_i,
  input  logic [OP_W-1:0]  op_y_i,
  input  logic [1:0]       rnd_mode_i,
  output logic             hit_o,
  output logic [OP_W-1:0]  word_o,
  output logic             invalid_o
);
  localparam logic [OP_W-1:0] QBIT = OP_W'(1) << (FRAC_W - 1);

  always_comb begin
    hit_o     = 1'b1;
    invalid_o = 1'b0;
    word_o    = '0;
    if (cls_x_i == CLS_SNAN) begin
      word_o = op_x_i | QBIT;  invalid_o = 1'b1;
    end else if (cls_y_i == CLS_SNAN) begin
      word_o = op_y_i | QBIT;  invalid_o = 1'b1;
    end else if (cls_x_i == CLS_QNAN) begin
      word_o = op_x_i;
    end else if (cls_y_i == CLS_QNAN) begin
      word_o = op_y_i;
    end else if (cls_x_i == CLS_INF && cls_y_i == CLS_INF) begin
      if (sx_i == sy_i) word_o = op_x_i;
      else begin word_o = DEF_NAN; invalid_o = 1'b1; end
    end else if (cls_x_i == CLS_INF) begin
      word_o = op_x_i;
    end else if (cls_y_i == CLS_INF) begin
      word_o = op_y_i;
    end else if (cls_x_i == CLS_ZERO && cls_y_i == CLS_ZERO) begin
      word_o = {(sx_i == sy_i) ? sx_i : (rnd_mode_i == RM_DOWN), {(OP_W-1){1'b0}}};
    end else if (cls_x_i == CLS_ZERO) begin
      word_o = op_y_i;
    end else if (cls_y_i == CLS_ZERO) begin
      word_o = op_x_i;
    end else begin
      hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_datapath.sv
module fpadd_datapath #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int XE_W  = EXP_W + 2,
  localparam int SIG_W = FRAC_W + 4
) (
  input  logic                    sx_i,
  input  logic                    sy_i,
  input  logic signed [XE_W-1:0]  ex_i,
  input  logic signed [XE_W-1:0]  ey_i,
  input  logic [SIG_W-1:0]        mx_i,
  input  logic [SIG_W-1:0]        my_i,
  output logic                    sign_o,
  output logic signed [XE_W-1:0]  exp_o,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    cancel_o
);
  function automatic logic [SIG_W-1:0] shr_sticky(input logic [SIG_W-1:0] m,
                                                  input logic [XE_W-1:0] d);
    logic [SIG_W-1:0] mask;
    if (d >= XE_W'(SIG_W)) return {{(SIG_W-1){1'b0}}, |m};
    mask = ~({SIG_W{1'b1}} << d);
    return (m >> d) | {{(SIG_W-1){1'b0}}, |(m & mask)};
  endfunction

  logic                   x_big;
  logic [XE_W-1:0]        diff, lsh;
  logic [SIG_W-1:0]       xa, ya, mag;
  logic [SIG_W:0]         sum;
  logic signed [XE_W-1:0] e_al;

  always_comb begin
    x_big = (ex_i >= ey_i);
    diff  = x_big ? XE_W'(ex_i - ey_i) : XE_W'(ey_i - ex_i);
    xa    = x_big ? mx_i : shr_sticky(mx_i, diff);
    ya    = x_big ? shr_sticky(my_i, diff) : my_i;
    e_al  = x_big ? ex_i : ey_i;
    sum   = {1'b0, xa} + {1'b0, ya};
    mag   = '0;
    lsh   = '0;
    cancel_o = 1'b0;
    if (sx_i == sy_i) begin
      sign_o = sx_i;
      if (sum[SIG_W]) begin
        sig_o = sum[SIG_W:1] | {{(SIG_W-1){1'b0}}, sum[0]};
        exp_o = XE_W'(e_al + 1);
      end else begin
        sig_o = sum[SIG_W-1:0];
        exp_o = e_al;
      end
    end else begin
      if (xa >= ya) begin mag = xa - ya; sign_o = sx_i; end
      else          begin mag = ya - xa; sign_o = sy_i; end
      cancel_o = (mag == '0);
      for (int i = 0; i < SIG_W; i++)
        if (mag[i]) lsh = XE_W'(SIG_W - 1 - i);
      sig_o = mag << lsh;
      exp_o = XE_W'(e_al - $signed(lsh));
    end
  end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter logic [EXP_W+FRAC_W:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}},
  localparam int OP_W  = 1 + EXP_W + FRAC_W,
  localparam int XE_W  = EXP_W + 2,
  localparam int SIG_W = FRAC_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [1:0]       rnd_mode_i,
  input  logic             ftz_i,
  output logic             valid_o,
  output logic             special_o,
  output logic [OP_W-1:0]  special_word_o,
  output logic             sign_o,
  output logic [XE_W-1:0]  exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             invalid_o
);
  logic [OP_W-1:0]        ops  [2];
  op_cls_e                cls  [2];
  logic                   sgn  [2];
  logic signed [XE_W-1:0] exps [2];
  logic [SIG_W-1:0]       sigs [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .op_i   (ops[g]),
      .ftz_i  (ftz_i),
      .cls_o  (cls[g]),
      .sign_o (sgn[g]),
      .exp_o  (exps[g]),
      .sig_o  (sigs[g])
    );
  end

  logic            sp_hit, sp_inv;
  logic [OP_W-1:0] sp_word;

  fpadd_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEF_NAN(DEF_NAN)) u_special (
    .cls_x_i    (cls[0]),
    .cls_y_i    (cls[1]),
    .sx_i       (sgn[0]),
    .sy_i       (sgn[1]),
    .op_x_i     (op_a_i),
    .op_y_i     (op_b_i),
    .rnd_mode_i (rnd_mode_i),
    .hit_o      (sp_hit),
    .word_o     (sp_word),
    .invalid_o  (sp_inv)
  );

  logic                   dp_sign, dp_cancel;
  logic signed [XE_W-1:0] dp_exp;
  logic [SIG_W-1:0]       dp_sig;

  fpadd_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_datapath (
    .sx_i     (sgn[0]),
    .sy_i     (sgn[1]),
    .ex_i     (exps[0]),
    .ey_i     (exps[1]),
    .mx_i     (sigs[0]),
    .my_i     (sigs[1]),
    .sign_o   (dp_sign),
    .exp_o    (dp_exp),
    .sig_o    (dp_sig),
    .cancel_o (dp_cancel)
  );

  logic            fin_hit;
  logic [OP_W-1:0] fin_word;
  assign fin_hit  = sp_hit | dp_cancel;
  assign fin_word = sp_hit ? sp_word : {rnd_mode_i == RM_DOWN, {(OP_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      special_o      <= 1'b0;
      invalid_o      <= 1'b0;
      special_word_o <= '0;
      sign_o         <= 1'b0;
      exp_o          <= '0;
      sig_o          <= '0;
    end else begin
      valid_o   <= valid_i;
      special_o <= valid_i & fin_hit;
      invalid_o <= valid_i & sp_hit & sp_inv;
      if (valid_i) begin
        special_word_o <= fin_word;
        sign_o         <= dp_sign;
        exp_o          <= dp_exp;
        sig_o          <= dp_sig;
      end
    end
  end
endmodule

// File: rtl/fpadd_core_chk.sv
module fpadd_core_chk #(
  parameter int EXP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic             special_o,
  input logic             invalid_o,
  input logic [EXP_W:0]   nan_field_i,
  input logic             sig_msb_i
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  p_valid_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  p_flags_need_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (special_o || invalid_o) |-> valid_o);

  // R1/R3: an invalid result is always a quiet NaN word
  p_invalid_quiet_nan_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (special_o && (&nan_field_i)));

  p_normalized_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !special_o) |-> sig_msb_i);
endmodule

bind fpadd_core fpadd_core_chk #(.EXP_W(EXP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .valid_o     (valid_o),
  .special_o   (special_o),
  .invalid_o   (invalid_o),
  .nan_field_i (special_word_o[OP_W-2:FRAC_W-1]),
  .sig_msb_i   (sig_o[SIG_W-1])
);

// File: tb/tb_fpadd_core.sv
`timescale 1ns/1ps
module tb_fpadd_core;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic ftz_i = 1'b0;
  logic [1:0] rm = 2'b00;
  logic [31:0] a32 = '0, b32 = '0;
  logic [7:0]  a8 = '0, b8 = '0;

  logic b_v, b_sp, b_sg, b_inv;
  logic [31:0] b_word;
  logic [9:0]  b_exp;
  logic [26:0] b_sig;
  logic s_v, s_sp, s_sg, s_inv;
  logic [7:0]  s_word;
  logic [5:0]  s_exp;
  logic [6:0]  s_sig;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  fpadd_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_a_i(a32), .op_b_i(b32),
    .rnd_mode_i(rm), .ftz_i(ftz_i), .valid_o(b_v), .special_o(b_sp),
    .special_word_o(b_word), .sign_o(b_sg), .exp_o(b_exp), .sig_o(b_sig), .invalid_o(b_inv));

  fpadd_core #(.EXP_W(4), .FRAC_W(3)) dut_s (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_a_i(a8), .op_b_i(b8),
    .rnd_mode_i(rm), .ftz_i(ftz_i), .valid_o(s_v), .special_o(s_sp),
    .special_word_o(s_word), .sign_o(s_sg), .exp_o(s_exp), .sig_o(s_sig), .invalid_o(s_inv));

  // class codes: 0 zero, 1 normal, 2 subnormal, 3 inf, 4 qnan, 5 snan
  function automatic int cls_of(input longint e, input longint f, input int ew,
                                input int fw, input bit ftz);
    longint emax = (longint'(1) << ew) - 1;
    if (e == 0) return (f == 0 || ftz) ? 0 : 2;
    if (e == emax) return (f == 0) ? 3 : (((f >> (fw - 1)) & 1) != 0 ? 4 : 5);
    return 1;
  endfunction

  function automatic void ref_add(input int ew, input int fw, input longint a, input longint b,
      input logic [1:0] r, input bit z, output bit spec, output longint word, output bit inv,
      output bit sg, output int ex, output longint sig, output string tg);
    longint one = 1;
    longint emax = (one << ew) - 1, qb = one << (fw - 1), fm = (one << fw) - 1;
    int w = 1 + ew + fw;
    bit sa = bit'((a >> (w - 1)) & 1), sb = bit'((b >> (w - 1)) & 1);
    longint ea = (a >> fw) & emax, eb = (b >> fw) & emax, fa = a & fm, fb = b & fm;
    int ca = cls_of(ea, fa, ew, fw, z), cb = cls_of(eb, fb, ew, fw, z);
    bit flushed = z && ((ea == 0 && fa != 0) || (eb == 0 && fb != 0));
    longint ma, mb, res, d;
    int xa, xb, e;
    spec = 1; inv = 0; word = 0; sg = 0; ex = 0; sig = 0;
    if (ca == 5)                 begin word = a | qb; inv = 1; tg = "R1"; end
    else if (cb == 5)            begin word = b | qb; inv = 1; tg = "R1"; end
    else if (ca == 4)            begin word = a; tg = "R2"; end
    else if (cb == 4)            begin word = b; tg = "R2"; end
    else if (ca == 3 && cb == 3) begin
      tg = "R3";
      if (sa == sb) word = a; else begin word = (emax << fw) | qb; inv = 1; end
    end
    else if (ca == 3)            begin word = a; tg = "R3"; end
    else if (cb == 3)            begin word = b; tg = "R3"; end
    else if (ca == 0 && cb == 0) begin
      word = longint'((sa == sb) ? sa : (r == 2'b11)) << (w - 1);
      tg = flushed ? "R5" : "R4";
    end
    else if (ca == 0)            begin word = b; tg = flushed ? "R5" : "R4"; end
    else if (cb == 0)            begin word = a; tg = flushed ? "R5" : "R4"; end
    else begin
      ma = (ea == 0) ? fa : (fa | (one << fw)); xa = (ea == 0) ? 1 : int'(ea);
      mb = (eb == 0) ? fb : (fb | (one << fw)); xb = (eb == 0) ? 1 : int'(eb);
      while (ma < (one << fw)) begin ma = ma << 1; xa--; end
      while (mb < (one << fw)) begin mb = mb << 1; xb--; end
      ma = ma << 3; mb = mb << 3;
      if (xa >= xb) begin
        d = xa - xb; e = xa;
        mb = (d > 40) ? longint'(mb != 0) : ((mb >> d) | longint'((mb % (one << d)) != 0));
      end else begin
        d = xb - xa; e = xb;
        ma = (d > 40) ? longint'(ma != 0) : ((ma >> d) | longint'((ma % (one << d)) != 0));
      end
      tg = (ea == 0 || eb == 0) ? "R6" : "R7";
      if (sa == sb) begin
        res = ma + mb; sg = sa;
        if (res >= (one << (fw + 4))) begin res = (res >> 1) | (res & 1); e++; end
        if (tg == "R7" && d == 0) tg = "R8";
      end else begin
        if (ma >= mb) begin res = ma - mb; sg = sa; end
        else          begin res = mb - ma; sg = sb; end
        if (tg == "R7" && d == 0) tg = "R9";
        if (res == 0) begin
          word = longint'(r == 2'b11) << (w - 1);
          tg = "R9";
          return;
        end
        while (res < (one << (fw + 3))) begin res = res << 1; e--; end
      end
      spec = 0; ex = e; sig = res;
    end
  endfunction

  task automatic judge(input string tag, input int ew, input int fw, input longint a,
      input longint b, input logic [1:0] r, input bit z, input bit gv, input bit gsp,
      input longint gword, input bit ginv, input bit gsg, input int gex, input longint gsig);
    bit esp, einv, esg, ok;
    longint eword, esig;
    int eex;
    string rt, t;
    ref_add(ew, fw, a, b, r, z, esp, eword, einv, esg, eex, esig, rt);
    t = (tag == "") ? rt : tag;
    n_tests++;
    ok = gv && (gsp == esp) &&
         (esp ? (gword == eword && ginv == einv)
              : (!ginv && gsg == esg && gex == eex && gsig == esig));
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h rm=%0d ftz=%0b: got v=%0b sp=%0b w=%h inv=%0b s=%0b e=%0d m=%h, expected sp=%0b w=%h inv=%0b s=%0b e=%0d m=%h",
               t, a, b, r, z, gv, gsp, gword, ginv, gsg, gex, gsig, esp, eword, einv, esg, eex, esig);
    end
    if (!esp) begin  // R10: leading one at the top of the significand
      n_tests++;
      if (((gsig >> (fw + 3)) & 1) != 1) begin
        n_fail++;
        $display("FAIL R10 a=%h b=%h: got m=%h, expected top bit 1", a, b, gsig);
      end
    end
  endtask

  task automatic step(input logic [31:0] ab, input logic [31:0] bb, input logic [7:0] as,
      input logic [7:0] bs, input logic [1:0] r, input bit z, input bit cb, input bit cs,
      input string tag);
    @(negedge clk);
    a32 = ab; b32 = bb; a8 = as; b8 = bs; rm = r; ftz_i = z; valid_i = 1'b1;
    @(posedge clk); #2;
    if (cb) judge(tag, 8, 23, longint'(ab), longint'(bb), r, z, b_v, b_sp, longint'(b_word),
                  b_inv, b_sg, int'($signed(b_exp)), longint'(b_sig));
    if (cs) judge(tag, 4, 3, longint'(as), longint'(bs), r, z, s_v, s_sp, longint'(s_word),
                  s_inv, s_sg, int'($signed(s_exp)), longint'(s_sig));
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    valid_i = 1'b0;
    @(posedge clk); #2;
    n_tests++;
    if (b_v || b_sp || b_inv) begin
      n_fail++;
      $display("FAIL %s idle: got v=%0b sp=%0b inv=%0b, expected 0 0 0", tag, b_v, b_sp, b_inv);
    end
  endtask

  task automatic big(input logic [31:0] ab, input logic [31:0] bb, input logic [1:0] r,
                     input bit z, input string tag);
    step(ab, bb, 8'h00, 8'h00, r, z, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_tests++;
    if (b_v || b_sp || b_inv || s_v) begin  // R11 reset state
      n_fail++;
      $display("FAIL R11 reset: got v=%0b sp=%0b inv=%0b, expected 0 0 0", b_v, b_sp, b_inv);
    end
    @(negedge clk) rst_ni = 1'b1;

    big(32'h7F800001, 32'hFF800002, 2'b00, 1'b0, "R1");
    idle_check("R11");
    big(32'h3F800000, 32'hFF800005, 2'b00, 1'b0, "R1");
    big(32'h7FC00123, 32'hFFC00456, 2'b00, 1'b0, "R2");
    big(32'h3F800000, 32'hFFC00456, 2'b00, 1'b0, "R2");
    big(32'h7F800000, 32'hFF800000, 2'b00, 1'b0, "R3");
    idle_check("R11");
    big(32'h7F800000, 32'h7F800000, 2'b00, 1'b0, "R3");
    big(32'h3F800000, 32'hFF800000, 2'b00, 1'b0, "R3");
    big(32'h00000000, 32'h80000000, 2'b00, 1'b0, "R4");
    big(32'h00000000, 32'h80000000, 2'b11, 1'b0, "R4");
    big(32'h80000000, 32'h80000000, 2'b00, 1'b0, "R4");
    big(32'h00000000, 32'h3F800000, 2'b00, 1'b0, "R4");
    big(32'h00000001, 32'h80000000, 2'b00, 1'b1, "R5");
    big(32'h80400000, 32'h3F800000, 2'b00, 1'b1, "R5");
    big(32'h00000001, 32'h00000001, 2'b00, 1'b0, "R6");
    big(32'h00400000, 32'h3F800000, 2'b00, 1'b0, "R6");
    big(32'h3F800000, 32'h30800001, 2'b00, 1'b0, "R7");
    big(32'h3F800000, 32'hB0800001, 2'b00, 1'b0, "R7");
    big(32'h3FC00000, 32'h3FC00000, 2'b00, 1'b0, "R8");
    big(32'h3F800000, 32'hBF800000, 2'b11, 1'b0, "R9");
    big(32'h3F800000, 32'hBFC00000, 2'b00, 1'b0, "R9");
    big(32'h3F800001, 32'hBF800000, 2'b00, 1'b0, "R10");

    // small format: every pair, rounding mode varied
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(32'h0, 32'h0, 8'(a), 8'(b), 2'(a + b), 1'b0, 1'b0, 1'b1, "");
    // flushing on: every pair holding a subnormal-coded operand
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        if (((a >> 3) & 15) == 0 || ((b >> 3) & 15) == 0)
          step(32'h0, 32'h0, 8'(a), 8'(b), 2'(a ^ b), 1'b1, 1'b0, 1'b1, "");
    idle_check("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule